// File: doc/BRIEF.md
# HDCP Repeater Capability and List-Ready Controller

This block holds the capability byte that an upstream HDCP 1.x transmitter reads over the display data channel from a repeater's receive port. It also runs the handshake that raises the list-ready flag in that byte. The block watches writes to the transmitter key-selection-vector (AKSV) byte registers. A write to the final byte marks the start of a new authentication, on the first attempt and on every later one. That write drops the ready flag, aborts any hash that is running, and raises an interrupt. The interrupt has a raw bit, a mask-enable bit and a status bit.

Firmware programs the static capability flags and a list-ready control bit through a small register port. When the control bit goes from 0 to 1, the block sends a one-cycle start to an external hash engine and is then busy. On the engine's done pulse, it stores the 160-bit verification value V' and sets the ready flag. The control bit never clears itself. To get the ready flag back after each new authentication, firmware must clear the bit and then set it again. The hash engine, the DDC slave, KSV list storage and the video path all live outside this block.

Firmware register map: address 0 is control, address 1 is interrupt mask, address 2 is interrupt clear. Only byte writes are supported. The capability byte is driven combinationally from the block's registers.

Top module: `hdcp_bcaps_ready_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the following all read 0: the capability byte, irq_raw, irq_status, vprime_rd, hash_start, hash_busy and ctrl_rd.
- R2: The capability byte is built from the control register at address 0, with the unlisted bits always 0:
  - bit 6 is the repeater flag, from control bit 1;
  - bit 5 is the ready flag;
  - bit 4 is fast DDC, from control bit 2;
  - bit 1 is HDMI features, from control bit 3;
  - bit 0 is fast re-authentication, from control bit 4.
- R3: A write to AKSV byte index AKSV_BYTES-1 (index 4 by default) clears the ready flag. The capability byte shows 0 in the cycle after that write, on every authentication. Writes to the lower indices leave the flag unchanged.
- R4: An AKSV write to the final byte sets irq_raw. A firmware write with data bit 0 = 1 to address 2 clears it. If both happen in the same cycle, the set wins. irq_status equals irq_raw AND mask, where mask is bit 0 of the register at address 1.
- R5: A firmware write that takes control bit 0 (list-ready) from 0 to 1 has three effects in the next cycle: a one-cycle hash_start pulse, hash_busy = 1, and the ready flag = 0.
- R6: A hash_done pulse while busy has two effects in the next cycle: V' is loaded from hash_value and the ready flag is set. A hash_done pulse while idle has no effect.
- R7: vprime_rd reads all zeros whenever hash_busy is 1. Otherwise it reads the last stored V'.
- R8: Hardware never clears list-ready. Writing 1 to it while it is already 1 starts no hash. So after an AKSV write, the ready flag stays 0 until firmware writes 0 and then 1.
- R9: A final-byte AKSV write while busy aborts the hash. hash_busy drops, the ready flag stays 0, and V' keeps its previous value, even if hash_done arrives in that same cycle.
- R10: ctrl_rd returns control bits [4:0] with the upper bits 0. mask_rd returns the mask in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aksv_wr | input | 1 | DDC-side write strobe to an AKSV byte |
| aksv_idx | input | 3 | AKSV byte index of the write |
| fw_we | input | 1 | Firmware register write strobe |
| fw_addr | input | 2 | Firmware register address |
| fw_wdata | input | 8 | Firmware write data |
| hash_done | input | 1 | Hash engine completion pulse |
| hash_value | input | 160 | Hash engine result |
| bcaps | output | 8 | Capability byte seen by the transmitter |
| irq_raw | output | 1 | Raw AKSV-update interrupt |
| irq_status | output | 1 | Masked AKSV-update interrupt |
| hash_start | output | 1 | One-cycle start to the hash engine |
| hash_busy | output | 1 | Hash in progress |
| vprime_rd | output | 160 | V' read value |
| ctrl_rd | output | 8 | Control register readback |
| mask_rd | output | 8 | Interrupt mask readback |

## Verification
Several internal faults show up within one cycle on the capability byte:
- A stale ready flag is visible in the cycle after the final AKSV byte is written, which is the re-authentication failure this block exists to prevent.
- An edge detector that fires on a level would emit a hash_start and later raise the ready flag while list-ready is merely held at 1.
- A lost abort would load a stale V' and raise the ready flag one cycle after the engine finishes.

A V' register that is not masked while busy appears on vprime_rd at once.

// File: rtl/hdcp_rdy_pkg.sv
package hdcp_rdy_pkg;
   // capability byte bit positions (decoded by the upstream transmitter)
   localparam int CAP_FAST_REAUTH = 0;
   localparam int CAP_HDMI        = 1;
   localparam int CAP_FAST_DDC    = 4;
   localparam int CAP_READY       = 5;
   localparam int CAP_REPEATER    = 6;

   // control register bit positions
   localparam int CTL_LIST_RDY    = 0;
   localparam int CTL_REPEATER    = 1;
   localparam int CTL_FAST_DDC    = 2;
   localparam int CTL_HDMI        = 3;
   localparam int CTL_FAST_REAUTH = 4;
   localparam int CTL_W           = 5;

   // firmware register addresses
   localparam logic [1:0] FA_CTRL = 2'd0;
   localparam logic [1:0] FA_MASK = 2'd1;
   localparam logic [1:0] FA_CLR  = 2'd2;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_BUSY  = 2'd1,
      SEQ_VALID = 2'd2
   } seq_state_t;
endpackage

// File: rtl/hdcp_aksv_watch.sv
module hdcp_aksv_watch #(
   parameter int AKSV_BYTES = 5,
   localparam int IDX_W = (AKSV_BYTES > 1) ? $clog2(AKSV_BYTES) : 1
) (
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   output logic             last_wr
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(AKSV_BYTES - 1);

   generate
      if (AKSV_BYTES < 1) begin : g_bad_bytes
         $error("AKSV_BYTES must be at least 1");
      end
      if (AKSV_BYTES == 1) begin : g_single
         assign last_wr = wr;
      end else begin : g_multi
         assign last_wr = wr && (idx == LAST_IDX);
      end
   endgenerate
endmodule

// File: rtl/hdcp_irq_bits.sv
module hdcp_irq_bits #(
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_ev,
   input  logic [N-1:0] clr_ev,
   input  logic         mask_we,
   input  logic [N-1:0] mask_wdata,
   output logic [N-1:0] raw,
   output logic [N-1:0] mask,
   output logic [N-1:0] status
);
   generate
      if (N < 1) begin : g_bad_n
         $error("N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (rst) begin
               raw[i] <= 1'b0;
            end else if (set_ev[i]) begin
               raw[i] <= 1'b1;   // set beats clear
            end else if (clr_ev[i]) begin
               raw[i] <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               mask[i] <= 1'b0;
            end else if (mask_we) begin
               mask[i] <= mask_wdata[i];
            end
         end

         assign status[i] = raw[i] & mask[i];
      end
   endgenerate
endmodule

// File: rtl/hdcp_vprime_seq.sv
module hdcp_vprime_seq
   import hdcp_rdy_pkg::*;
#(
   parameter int VP_W            = 160,
   parameter bit ZERO_WHILE_BUSY = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start_req,
   input  logic            abort,
   input  logic            done,
   input  logic [VP_W-1:0] value,
   output logic            start_pulse,
   output logic            busy,
   output logic            ready,
   output logic [VP_W-1:0] vp_rd
);
   seq_state_t      st_q;
   logic [VP_W-1:0] vp_q;

   generate
      if (VP_W % 32 != 0) begin : g_bad_vp
         $error("VP_W must be a multiple of 32");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q        <= SEQ_IDLE;
         start_pulse <= 1'b0;
      end else begin
         start_pulse <= start_req;
         if (start_req) begin
            st_q <= SEQ_BUSY;
         end else if (abort) begin
            st_q <= SEQ_IDLE;
         end else if (st_q == SEQ_BUSY && done) begin
            st_q <= SEQ_VALID;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vp_q <= '0;
      end else if (st_q == SEQ_BUSY && done && !abort && !start_req) begin
         vp_q <= value;
      end
   end

   assign busy  = (st_q == SEQ_BUSY);
   assign ready = (st_q == SEQ_VALID);

   generate
      if (ZERO_WHILE_BUSY) begin : g_mask_rd
         assign vp_rd = busy ? '0 : vp_q;
      end else begin : g_raw_rd
         assign vp_rd = vp_q;
      end
   endgenerate
endmodule

// File: rtl/hdcp_bcaps_ready_ctrl.sv
module hdcp_bcaps_ready_ctrl
   import hdcp_rdy_pkg::*;
#(
   parameter int AKSV_BYTES = 5,
   parameter int VP_W       = 160,
   parameter int IDX_W      = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             aksv_wr,
   input  logic [IDX_W-1:0] aksv_idx,
   input  logic             fw_we,
   input  logic [1:0]       fw_addr,
   input  logic [7:0]       fw_wdata,
   input  logic             hash_done,
   input  logic [VP_W-1:0]  hash_value,
   output logic [7:0]       bcaps,
   output logic             irq_raw,
   output logic             irq_status,
   output logic             hash_start,
   output logic             hash_busy,
   output logic [VP_W-1:0]  vprime_rd,
   output logic [7:0]       ctrl_rd,
   output logic [7:0]       mask_rd
);
   localparam int IDX_MIN = (AKSV_BYTES > 1) ? $clog2(AKSV_BYTES) : 1;

   generate
      if (IDX_W != IDX_MIN) begin : g_bad_idx
         $error("IDX_W must equal clog2(AKSV_BYTES)");
      end
   endgenerate

   logic              aksv_last;
   logic [CTL_W-1:0]  ctrl_q;
   logic              wr_ctrl, wr_mask, wr_clr;
   logic              start_req;
   logic              ready;
   logic [0:0]        irq_raw_v, irq_mask_v, irq_stat_v;

   assign wr_ctrl = fw_we && (fw_addr == FA_CTRL);
   assign wr_mask = fw_we && (fw_addr == FA_MASK);
   assign wr_clr  = fw_we && (fw_addr == FA_CLR);

   hdcp_aksv_watch #(.AKSV_BYTES(AKSV_BYTES)) u_watch (
      .wr      (aksv_wr),
      .idx     (aksv_idx),
      .last_wr (aksv_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= fw_wdata[CTL_W-1:0];
      end
   end

   // new hash only on a 0->1 edge of list-ready
   assign start_req = wr_ctrl && fw_wdata[CTL_LIST_RDY] && !ctrl_q[CTL_LIST_RDY];

   hdcp_irq_bits #(.N(1)) u_irq (
      .clk        (clk),
      .rst        (rst),
      .set_ev     (aksv_last),
      .clr_ev     (wr_clr && fw_wdata[0]),
      .mask_we    (wr_mask),
      .mask_wdata (fw_wdata[0]),
      .raw        (irq_raw_v),
      .mask       (irq_mask_v),
      .status     (irq_stat_v)
   );

   hdcp_vprime_seq #(.VP_W(VP_W), .ZERO_WHILE_BUSY(1'b1)) u_seq (
      .clk         (clk),
      .rst         (rst),
      .start_req   (start_req),
      .abort       (aksv_last),
      .done        (hash_done),
      .value       (hash_value),
      .start_pulse (hash_start),
      .busy        (hash_busy),
      .ready       (ready),
      .vp_rd       (vprime_rd)
   );

   assign irq_raw    = irq_raw_v[0];
   assign irq_status = irq_stat_v[0];

   always_comb begin
      bcaps                  = '0;
      bcaps[CAP_REPEATER]    = ctrl_q[CTL_REPEATER];
      bcaps[CAP_READY]       = ready;
      bcaps[CAP_FAST_DDC]    = ctrl_q[CTL_FAST_DDC];
      bcaps[CAP_HDMI]        = ctrl_q[CTL_HDMI];
      bcaps[CAP_FAST_REAUTH] = ctrl_q[CTL_FAST_REAUTH];
   end

   assign ctrl_rd = {{(8-CTL_W){1'b0}}, ctrl_q};
   assign mask_rd = {7'b0, irq_mask_v[0]};
endmodule

// File: rtl/hdcp_bcaps_ready_chk.sv
module hdcp_bcaps_ready_chk #(
   parameter int AKSV_BYTES = 5,
   parameter int VP_W       = 160,
   parameter int IDX_W      = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             aksv_wr,
   input logic [IDX_W-1:0] aksv_idx,
   input logic             hash_done,
   input logic [7:0]       bcaps,
   input logic             irq_raw,
   input logic             irq_status,
   input logic             hash_start,
   input logic             hash_busy,
   input logic [VP_W-1:0]  vprime_rd
);
   logic last_ev;
   assign last_ev = aksv_wr && (aksv_idx == IDX_W'(AKSV_BYTES - 1));

   p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
      last_ev |=> !bcaps[5]);

   p_raw_set_r4: assert property (@(posedge clk) disable iff (rst)
      last_ev |=> irq_raw);

   p_status_gated_r4: assert property (@(posedge clk) disable iff (rst)
      irq_status |-> irq_raw);

   p_start_single_r5: assert property (@(posedge clk) disable iff (rst)
      hash_start |=> !hash_start);

   p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
      hash_start |-> hash_busy && !bcaps[5]);

   p_ready_after_done_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(bcaps[5]) |-> $past(hash_done && hash_busy && !last_ev));

   p_vp_hidden_r7: assert property (@(posedge clk) disable iff (rst)
      hash_busy |-> (vprime_rd == '0));

   p_abort_r9: assert property (@(posedge clk) disable iff (rst)
      (hash_busy && last_ev) |=> !bcaps[5]);
endmodule

bind hdcp_bcaps_ready_ctrl hdcp_bcaps_ready_chk #(
   .AKSV_BYTES(AKSV_BYTES), .VP_W(VP_W), .IDX_W(IDX_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .aksv_wr    (aksv_wr),
   .aksv_idx   (aksv_idx),
   .hash_done  (hash_done),
   .bcaps      (bcaps),
   .irq_raw    (irq_raw),
   .irq_status (irq_status),
   .hash_start (hash_start),
   .hash_busy  (hash_busy),
   .vprime_rd  (vprime_rd)
);

// File: tb/sim_hdcp_bcaps_ready_ctrl.sv
module sim_hdcp_bcaps_ready_ctrl;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         aksv_wr = 1'b0;
   logic [2:0]   aksv_idx = '0;
   logic         fw_we = 1'b0;
   logic [1:0]   fw_addr = '0;
   logic [7:0]   fw_wdata = '0;
   logic         hash_done = 1'b0;
   logic [159:0] hash_value = '0;
   logic [7:0]   bcaps;
   logic         irq_raw, irq_status, hash_start, hash_busy;
   logic [159:0] vprime_rd;
   logic [7:0]   ctrl_rd, mask_rd;

   int checks = 0;
   int errors = 0;
   int eng_cnt = 0;
   bit done_flag = 0;

   // reference state
   logic [4:0]   m_ctrl;
   logic         m_mask, m_raw, m_busy, m_ready, m_start;
   logic [159:0] m_vp;

   always #10 clk = ~clk;

   hdcp_bcaps_ready_ctrl u0 (
      .clk(clk), .rst(rst), .aksv_wr(aksv_wr), .aksv_idx(aksv_idx),
      .fw_we(fw_we), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
      .hash_done(hash_done), .hash_value(hash_value),
      .bcaps(bcaps), .irq_raw(irq_raw), .irq_status(irq_status),
      .hash_start(hash_start), .hash_busy(hash_busy), .vprime_rd(vprime_rd),
      .ctrl_rd(ctrl_rd), .mask_rd(mask_rd)
   );

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_bcaps(input logic [4:0] c, input logic rdy);
      return {1'b0, c[1], rdy, c[2], 2'b00, c[3], c[4]};
   endfunction

   // advance the reference by one clock using the inputs now applied
   task automatic model_step();
      logic ev, st, clr;
      ev  = aksv_wr && (aksv_idx == 3'd4);
      st  = fw_we && fw_addr == 2'd0 && fw_wdata[0] && !m_ctrl[0];
      clr = fw_we && fw_addr == 2'd2 && fw_wdata[0];
      if (!st && !ev && m_busy && hash_done) m_vp = hash_value;
      if (st) begin
         m_busy = 1; m_ready = 0;
      end else if (ev) begin
         m_busy = 0; m_ready = 0;
      end else if (m_busy && hash_done) begin
         m_busy = 0; m_ready = 1;
      end
      m_start = st;
      if (ev) m_raw = 1;
      else if (clr) m_raw = 0;
      if (fw_we && fw_addr == 2'd1) m_mask = fw_wdata[0];
      if (fw_we && fw_addr == 2'd0) m_ctrl = fw_wdata[4:0];
   endtask

   task automatic compare_all();
      chk("R2/R3 bcaps", 160'(bcaps), 160'(exp_bcaps(m_ctrl, m_ready)));
      chk("R4 irq_raw", 160'(irq_raw), 160'(m_raw));
      chk("R4 irq_status", 160'(irq_status), 160'(m_raw & m_mask));
      chk("R5 hash_start", 160'(hash_start), 160'(m_start));
      chk("R5 hash_busy", 160'(hash_busy), 160'(m_busy));
      chk("R6/R7 vprime_rd", vprime_rd, m_busy ? 160'd0 : m_vp);
      chk("R10 ctrl_rd", 160'(ctrl_rd), 160'({3'b0, m_ctrl}));
      chk("R10 mask_rd", 160'(mask_rd), 160'({7'b0, m_mask}));
   endtask

   // one clock: inputs already applied; sample 2 ns after the edge
   task automatic cyc();
      model_step();
      @(posedge clk);
      #2;
      compare_all();
      aksv_wr = 0; fw_we = 0; hash_done = 0;
   endtask

   task automatic fw(input logic [1:0] a, input logic [7:0] d);
      fw_we = 1; fw_addr = a; fw_wdata = d; cyc();
   endtask

   task automatic aksv(input logic [2:0] i);
      aksv_wr = 1; aksv_idx = i; cyc();
   endtask

   task automatic done_with(input logic [159:0] v);
      hash_done = 1; hash_value = v; cyc();
   endtask

   function automatic logic [159:0] rnd160();
      return {$urandom, $urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      logic [159:0] v1, v2;
      void'($urandom(32'h5eed_0bca));
      m_ctrl = 0; m_mask = 0; m_raw = 0; m_busy = 0; m_ready = 0; m_start = 0; m_vp = 0;
      repeat (3) @(posedge clk);
      #2; rst = 0;
      // R1: reset state
      compare_all();
      chk("R1 bcaps reset", 160'(bcaps), 160'd0);

      // R2: static flags, list-ready off
      fw(2'd0, 8'b0001_1110);
      chk("R2 layout", 160'(bcaps), 160'(8'h53));
      fw(2'd1, 8'h01);

      // first authentication: lower bytes then final byte
      for (int i = 0; i < 4; i++) aksv(3'(i));
      chk("R4 raw clear before final", 160'(irq_raw), 160'd0);
      aksv(3'd4);
      chk("R4 raw set", 160'(irq_raw), 160'd1);
      v1 = rnd160();
      fw(2'd0, 8'b0001_1111);
      chk("R5 start", 160'(hash_start), 160'd1);
      cyc();
      chk("R5 pulse once", 160'(hash_start), 160'd0);
      chk("R7 hidden", vprime_rd, 160'd0);
      done_with(v1);
      chk("R6 ready set", 160'(bcaps[5]), 160'd1);
      chk("R6 vp latched", vprime_rd, v1);

      // lower-byte write leaves READY
      aksv(3'd2);
      chk("R3 lower byte keeps ready", 160'(bcaps[5]), 160'd1);
      // re-authentication with list-ready stuck at 1
      aksv(3'd4);
      chk("R3 ready drops on reauth", 160'(bcaps[5]), 160'd0);
      fw(2'd0, 8'b0001_1111);
      chk("R8 no start on stuck bit", 160'(hash_start), 160'd0);
      done_with(rnd160());
      chk("R6 idle done ignored", 160'(bcaps[5]), 160'd0);
      chk("R8 ready still 0", vprime_rd, v1);
      chk("R8 bit not self-cleared", 160'(ctrl_rd[0]), 160'd1);

      // W1C vs set same cycle: set wins
      fw_we = 1; fw_addr = 2'd2; fw_wdata = 8'h01; aksv_wr = 1; aksv_idx = 3'd4; cyc();
      chk("R4 set beats clear", 160'(irq_raw), 160'd1);
      fw(2'd2, 8'h01);
      chk("R4 w1c", 160'(irq_raw), 160'd0);

      // abort: clear, set, then AKSV together with done
      fw(2'd0, 8'b0001_1110);
      fw(2'd0, 8'b0001_1111);
      cyc();
      v2 = rnd160();
      hash_done = 1; hash_value = v2; aksv_wr = 1; aksv_idx = 3'd4; cyc();
      chk("R9 abort busy", 160'(hash_busy), 160'd0);
      chk("R9 abort ready", 160'(bcaps[5]), 160'd0);
      chk("R9 vp kept", vprime_rd, v1);

      // random phase; engine answers 1..5 cycles after start
      eng_cnt = 0;
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom % 100;
         if (r < 8) begin
            aksv_wr = 1; aksv_idx = 3'($urandom % 5);
         end
         if (r >= 50 && r < 75) begin
            fw_we = 1; fw_addr = 2'($urandom % 4);
            fw_wdata = 8'($urandom);
         end
         if (eng_cnt == 1 || (eng_cnt == 0 && ($urandom % 20) == 0)) begin
            hash_done = 1; hash_value = rnd160();
         end
         model_step();
         @(posedge clk);
         #2;
         compare_all();
         aksv_wr = 0; fw_we = 0; hash_done = 0;
         if (eng_cnt > 0) eng_cnt--;
         if (hash_start) eng_cnt = 1 + ($urandom % 5);
      end

      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule